// File: doc/BRIEF.md
# Handshaked Byte-Serial Command Engine

This block is the device side of a byte-wide command link. A host moves one byte at a time through a shared shift-register port. Each byte is paced by two active-low lines: a request that the host drives (`req_ni`) and an acknowledge that this block drives back (`ack_no`). The engine has four phases: idle, command receive, executor wait and response send.

The first byte of a packet is the opcode. A built-in opcode table gives two things for each opcode: the command length and the response length. Either length is a fixed count or is marked variable. A variable command length arrives as the first argument byte. A variable response length is sent as the first response byte. Argument bytes are stored in a command buffer.

For opcodes that an external executor handles, the engine pulses a dispatch strobe once the command is complete. It then holds off further host requests until the executor signals completion, having filled the response buffer. For opcodes that no executor handles, the engine answers by itself. With a fixed response length it sends that many zero bytes. With a variable response length it sends an empty response.

Top module: `hs_cmd_engine`

## Requirements
- R1: After reset, `ack_no` is 1, `phase_o` is 0 (idle), `sr_data_o` is 0, and `sr_irq_o` and `dispatch_valid_o` are 0.
- R2: Handshake behaviour:
  - When `req_ni` is low while `ack_no` is high, the block lowers `ack_no` and handles exactly one byte, however long `req_ni` stays low.
  - When `req_ni` is high while `ack_no` is low, the block raises `ack_no` on the next clock.
  - `ack_no` falls only while `req_ni` is low.
- R3: While `phase_o` is 2 (executor wait), a pending request is not acknowledged. `ack_no` falls only after `dispatch_done_i` has been seen.
- R4: A byte taken in idle is the opcode. It is looked up in the table, both buffer positions are cleared, and the phase becomes 1 (command receive) unless the command length is a fixed zero. The table is:
  - 0x01: handled, command fixed 0, response fixed 4.
  - 0x02: handled, command fixed 4, response fixed 0.
  - 0x03: handled, command variable, response variable.
  - 0x04: handled, command fixed 1, response variable.
  - 0x05: not handled, command fixed 0, response fixed 3.
  - 0x06: not handled, command fixed 2, response variable.
  - Every other opcode: not handled, command fixed 0, response variable.
- R5: With a variable command length, the first byte received after the opcode is the length. It is not stored in the buffer.
- R6: Argument bytes fill the 32-entry command buffer in arrival order. Bytes past the 32nd are dropped, but they still count toward the command length.
- R7: When the received count equals the command length, a handled opcode raises `dispatch_valid_o` for exactly one cycle, carrying the opcode and the command length, and the phase becomes 2. An opcode with a fixed command length of zero dispatches straight from its opcode byte.
- R8: With a variable response length, the first byte sent is the response size. For a handled opcode this is `rsp_size_i` captured at `dispatch_done_i`, clamped to 32. Buffer bytes follow.
- R9: With a fixed response length, exactly that many bytes are sent from response-buffer entries 0, 1, 2 and so on. The phase then returns to 0.
- R10: A response with a fixed length of zero returns the phase to 0 directly after completion, with no byte exchanged. A variable-length response of size zero ends right after its size byte.
- R11: Transfer direction is checked on every byte: `sr_dir_h2d_i` must be 1 in idle and command receive, and 0 in response send. A byte with the wrong direction is still acknowledged. It pulses `proto_err_o`, raises no interrupt, and changes no phase, count or output byte.
- R12: Every byte consumed or loaded raises `sr_irq_o` for exactly one cycle.
- R13: An opcode that is not handled never raises `dispatch_valid_o`. Its response is the table's fixed count of zero bytes, or a size byte of 0 when the response length is variable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_ni | input | 1 | Host transfer request, active low |
| ack_no | output | 1 | Transfer acknowledge to host, active low |
| sr_dir_h2d_i | input | 1 | Shift-register direction: 1 host-to-device, 0 device-to-host |
| sr_data_i | input | 8 | Byte shifted in by the host |
| sr_data_o | output | 8 | Byte loaded for the host to shift out |
| sr_irq_o | output | 1 | One-cycle shift-register-complete interrupt |
| proto_err_o | output | 1 | One-cycle pulse on a direction error |
| phase_o | output | 2 | 0 idle, 1 command receive, 2 executor wait, 3 response send |
| dispatch_valid_o | output | 1 | One-cycle command-complete strobe to the executor |
| dispatch_op_o | output | 8 | Opcode of the current command |
| dispatch_len_o | output | 8 | Command length of the current command |
| dispatch_done_i | input | 1 | Executor completion pulse |
| rsp_size_i | input | 6 | Response size given by the executor, used when the response length is variable |
| cmd_rd_addr_i | input | 5 | Command buffer read index |
| cmd_rd_data_o | output | 8 | Command buffer read data |
| rsp_we_i | input | 1 | Response buffer write enable |
| rsp_waddr_i | input | 5 | Response buffer write index |
| rsp_wdata_i | input | 8 | Response buffer write data |

## Verification
The bound checker watches the handshake on every cycle. It checks that the acknowledge is released after the request is released, and that it falls only under an active request. It checks that no acknowledge falls during executor wait, that the dispatch strobe lasts one cycle and coincides with the wait phase, and that a protocol error never comes with an interrupt.

Packet-level behaviour can only be shown by the bench's scenarios. This covers:
- opcode table lookup and in-band length bytes;
- the 32-byte overflow drop;
- response ordering and the zero fill for opcodes that are not handled;
- early return to idle for empty responses;
- recovery after a wrong-direction byte.

// File: rtl/hs_cmd_pkg.sv
package hs_cmd_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CMD  = 2'd1,
    PH_EXEC = 2'd2,
    PH_RSP  = 2'd3
  } phase_e;

  typedef struct packed {
    logic       handled;
    logic       cmd_var;
    logic [7:0] cmd_len;
    logic       rsp_var;
    logic [7:0] rsp_len;
  } op_ent_t;

  function automatic op_ent_t op_lookup(input logic [7:0] op);
    op_ent_t e;
    e = '{handled: 1'b0, cmd_var: 1'b0, cmd_len: 8'd0, rsp_var: 1'b1, rsp_len: 8'd0};
    case (op)
      8'h01: e = '{handled: 1'b1, cmd_var: 1'b0, cmd_len: 8'd0, rsp_var: 1'b0, rsp_len: 8'd4};
      8'h02: e = '{handled: 1'b1, cmd_var: 1'b0, cmd_len: 8'd4, rsp_var: 1'b0, rsp_len: 8'd0};
      8'h03: e = '{handled: 1'b1, cmd_var: 1'b1, cmd_len: 8'd0, rsp_var: 1'b1, rsp_len: 8'd0};
      8'h04: e = '{handled: 1'b1, cmd_var: 1'b0, cmd_len: 8'd1, rsp_var: 1'b1, rsp_len: 8'd0};
      8'h05: e = '{handled: 1'b0, cmd_var: 1'b0, cmd_len: 8'd0, rsp_var: 1'b0, rsp_len: 8'd3};
      8'h06: e = '{handled: 1'b0, cmd_var: 1'b0, cmd_len: 8'd2, rsp_var: 1'b1, rsp_len: 8'd0};
      default: ;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/hs_handshake.sv
module hs_handshake (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  input  logic hold_i,
  output logic ack_no,
  output logic take_o
);
  logic ack_q, take_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q  <= 1'b1;
      take_q <= 1'b0;
    end else begin
      take_q <= 1'b0;
      if (!req_ni && ack_q && !hold_i) begin
        ack_q  <= 1'b0;
        take_q <= 1'b1;
      end else if (req_ni && !ack_q) begin
        ack_q <= 1'b1;
      end
    end
  end

  assign ack_no = ack_q;
  assign take_o = take_q;
endmodule

// File: rtl/hs_byte_buf.sv
module hs_byte_buf #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem[g] <= '0;
      else if (we_i && (waddr_i == AW'(g))) mem[g] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/hs_cmd_engine.sv
module hs_cmd_engine
  import hs_cmd_pkg::*;
#(
  parameter int unsigned BUF_DEPTH = 32,
  localparam int unsigned AW  = $clog2(BUF_DEPTH),
  localparam int unsigned SZW = $clog2(BUF_DEPTH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_ni,
  output logic           ack_no,
  input  logic           sr_dir_h2d_i,
  input  logic [7:0]     sr_data_i,
  output logic [7:0]     sr_data_o,
  output logic           sr_irq_o,
  output logic           proto_err_o,
  output logic [1:0]     phase_o,
  output logic           dispatch_valid_o,
  output logic [7:0]     dispatch_op_o,
  output logic [7:0]     dispatch_len_o,
  input  logic           dispatch_done_i,
  input  logic [SZW-1:0] rsp_size_i,
  input  logic [AW-1:0]  cmd_rd_addr_i,
  output logic [7:0]     cmd_rd_data_o,
  input  logic           rsp_we_i,
  input  logic [AW-1:0]  rsp_waddr_i,
  input  logic [7:0]     rsp_wdata_i
);
  phase_e     phase_q;
  logic       take;
  logic [7:0] op_q, cmd_len_q, rcnt_q, rsp_len_q, rsp_pos_q, sr_q;
  logic       len_pend_q, rsp_pend_q, rsp_zero_q;
  logic       hnd_q, rvar_q;
  logic [7:0] rlen_q;
  logic       irq_q, err_q, dv_q;

  hs_handshake i_hs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_ni (req_ni),
    .hold_i (phase_q == PH_EXEC),
    .ack_no (ack_no),
    .take_o (take)
  );

  // command buffer: engine writes, executor reads
  logic cmd_we;
  assign cmd_we = (phase_q == PH_CMD) && take && sr_dir_h2d_i && !len_pend_q &&
                  (rcnt_q < 8'(BUF_DEPTH));

  hs_byte_buf #(.DEPTH(BUF_DEPTH), .DW(8)) i_cmd_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cmd_we),
    .waddr_i (rcnt_q[AW-1:0]),
    .wdata_i (sr_data_i),
    .raddr_i (cmd_rd_addr_i),
    .rdata_o (cmd_rd_data_o)
  );

  // response buffer: executor writes, engine reads
  logic [7:0] rsp_rdata;
  hs_byte_buf #(.DEPTH(BUF_DEPTH), .DW(8)) i_rsp_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rsp_we_i),
    .waddr_i (rsp_waddr_i),
    .wdata_i (rsp_wdata_i),
    .raddr_i (rsp_pos_q[AW-1:0]),
    .rdata_o (rsp_rdata)
  );

  // table entry in effect: fresh lookup in idle, captured copy otherwise
  op_ent_t    ent_new;
  logic       cur_hnd, cur_rvar;
  logic [7:0] cur_rlen, unk_size;
  phase_e     dsp_phase;
  assign ent_new   = op_lookup(sr_data_i);
  assign cur_hnd   = (phase_q == PH_IDLE) ? ent_new.handled : hnd_q;
  assign cur_rvar  = (phase_q == PH_IDLE) ? ent_new.rsp_var : rvar_q;
  assign cur_rlen  = (phase_q == PH_IDLE) ? ent_new.rsp_len : rlen_q;
  assign unk_size  = cur_rvar ? 8'd0 : cur_rlen;
  assign dsp_phase = cur_hnd ? PH_EXEC :
                     ((!cur_rvar && unk_size == 8'd0) ? PH_IDLE : PH_RSP);

  logic [SZW-1:0] rsz_clamped;
  logic [7:0]     exec_size;
  assign rsz_clamped = (rsp_size_i > SZW'(BUF_DEPTH)) ? SZW'(BUF_DEPTH) : rsp_size_i;
  assign exec_size   = rvar_q ? 8'(rsz_clamped) : rlen_q;

  logic [7:0] rcnt_inc, pos_inc;
  assign rcnt_inc = rcnt_q + 8'd1;
  assign pos_inc  = rsp_pos_q + 8'd1;

  logic dsp_now;
  always_comb begin
    dsp_now = 1'b0;
    if (take && sr_dir_h2d_i) begin
      if (phase_q == PH_IDLE)
        dsp_now = !ent_new.cmd_var && (ent_new.cmd_len == 8'd0);
      else if (phase_q == PH_CMD)
        dsp_now = len_pend_q ? (sr_data_i == 8'd0) : (rcnt_inc == cmd_len_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      op_q       <= '0;
      cmd_len_q  <= '0;
      rcnt_q     <= '0;
      rsp_len_q  <= '0;
      rsp_pos_q  <= '0;
      sr_q       <= '0;
      len_pend_q <= 1'b0;
      rsp_pend_q <= 1'b0;
      rsp_zero_q <= 1'b0;
      hnd_q      <= 1'b0;
      rvar_q     <= 1'b0;
      rlen_q     <= '0;
      irq_q      <= 1'b0;
      err_q      <= 1'b0;
      dv_q       <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      err_q <= 1'b0;
      dv_q  <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (take) begin
          if (!sr_dir_h2d_i) err_q <= 1'b1;
          else begin
            irq_q      <= 1'b1;
            op_q       <= sr_data_i;
            hnd_q      <= ent_new.handled;
            rvar_q     <= ent_new.rsp_var;
            rlen_q     <= ent_new.rsp_len;
            cmd_len_q  <= ent_new.cmd_len;
            len_pend_q <= ent_new.cmd_var;
            rcnt_q     <= '0;
            rsp_pos_q  <= '0;
            if (!dsp_now) phase_q <= PH_CMD;
          end
        end
        PH_CMD: if (take) begin
          if (!sr_dir_h2d_i) err_q <= 1'b1;
          else begin
            irq_q <= 1'b1;
            if (len_pend_q) begin
              cmd_len_q  <= sr_data_i;
              len_pend_q <= 1'b0;
            end else begin
              rcnt_q <= rcnt_inc;
            end
          end
        end
        PH_EXEC: if (dispatch_done_i) begin
          rsp_zero_q <= 1'b0;
          rsp_len_q  <= exec_size;
          rsp_pend_q <= rvar_q;
          phase_q    <= (!rvar_q && exec_size == 8'd0) ? PH_IDLE : PH_RSP;
        end
        PH_RSP: if (take) begin
          if (sr_dir_h2d_i) err_q <= 1'b1;
          else begin
            irq_q <= 1'b1;
            if (rsp_pend_q) begin
              sr_q       <= rsp_len_q;
              rsp_pend_q <= 1'b0;
              if (rsp_len_q == 8'd0) phase_q <= PH_IDLE;
            end else begin
              sr_q      <= rsp_zero_q ? 8'd0 : rsp_rdata;
              rsp_pos_q <= pos_inc;
              if (pos_inc == rsp_len_q) phase_q <= PH_IDLE;
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
      // command complete: hand off to executor or answer locally
      if (dsp_now) begin
        dv_q       <= cur_hnd;
        rsp_zero_q <= 1'b1;
        rsp_len_q  <= unk_size;
        rsp_pend_q <= cur_rvar;
        phase_q    <= dsp_phase;
      end
    end
  end

  assign sr_data_o        = sr_q;
  assign sr_irq_o         = irq_q;
  assign proto_err_o      = err_q;
  assign phase_o          = phase_q;
  assign dispatch_valid_o = dv_q;
  assign dispatch_op_o    = op_q;
  assign dispatch_len_o   = cmd_len_q;
endmodule

// File: rtl/hs_cmd_engine_chk.sv
module hs_cmd_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_ni,
  input logic       ack_no,
  input logic       sr_irq_o,
  input logic       proto_err_o,
  input logic       dispatch_valid_o,
  input logic [1:0] phase_o
);
  AST_ACK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ni && !ack_no) |=> ack_no); // R2

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_no) |-> $past(!req_ni)); // R2

  AST_EXEC_HOLDS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd2 && ack_no) |=> ack_no); // R3

  AST_DISPATCH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dispatch_valid_o |=> !dispatch_valid_o); // R7

  AST_DISPATCH_IN_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dispatch_valid_o |-> (phase_o == 2'd2)); // R7

  AST_ERR_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |-> !sr_irq_o); // R11
endmodule

bind hs_cmd_engine hs_cmd_engine_chk i_chk (.*);

// File: tb/test_hs_cmd_engine.sv
module test_hs_cmd_engine;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_ni = 1'b1;
  logic       ack_no;
  logic       sr_dir_h2d_i = 1'b1;
  logic [7:0] sr_data_i = '0;
  logic [7:0] sr_data_o;
  logic       sr_irq_o, proto_err_o, dispatch_valid_o;
  logic [1:0] phase_o;
  logic [7:0] dispatch_op_o, dispatch_len_o;
  logic       dispatch_done_i = 1'b0;
  logic [5:0] rsp_size_i = '0;
  logic [4:0] cmd_rd_addr_i = '0;
  logic [7:0] cmd_rd_data_o;
  logic       rsp_we_i = 1'b0;
  logic [4:0] rsp_waddr_i = '0;
  logic [7:0] rsp_wdata_i = '0;

  hs_cmd_engine i_hs_cmd_engine (.*);

  always #2 clk_i = ~clk_i;

  int tests = 0, fails = 0;
  int cyc = 0, irq_cnt = 0, err_cnt = 0, dv_cnt = 0;
  int last_fall = 0, done_cyc = 0, exec_delay = 2;
  logic [7:0] dv_op, dv_len;
  logic [7:0] seen_cmd[$];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  // event monitor, sampled 1 ns after each rising edge
  always @(posedge clk_i) begin
    cyc++;
    #1;
    if (rst_ni) begin
      if (sr_irq_o) irq_cnt++;
      if (proto_err_o) err_cnt++;
      if (dispatch_valid_o) begin
        dv_cnt++;
        dv_op  = dispatch_op_o;
        dv_len = dispatch_len_o;
      end
    end
  end

  // behavioural executor
  initial begin
    forever begin
      @(negedge clk_i);
      if (dispatch_valid_o) begin
        automatic logic [7:0] op = dispatch_op_o;
        automatic int len = dispatch_len_o;
        automatic int nrd = (len > 32) ? 32 : len;
        automatic logic [7:0] rsp[$];
        seen_cmd = {};
        for (int i = 0; i < nrd; i++) begin
          cmd_rd_addr_i = 5'(i);
          #0.5;
          seen_cmd.push_back(cmd_rd_data_o);
        end
        case (op)
          8'h01: rsp = '{8'hA0, 8'hA1, 8'hA2, 8'hA3};
          8'h03: rsp = seen_cmd;
          8'h04: for (int i = 0; i < int'(seen_cmd[0]); i++) rsp.push_back(8'(8'h50 + i));
          default: rsp = {};
        endcase
        @(negedge clk_i);
        repeat (exec_delay) @(negedge clk_i);
        foreach (rsp[i]) begin
          rsp_we_i = 1'b1; rsp_waddr_i = 5'(i); rsp_wdata_i = rsp[i];
          @(negedge clk_i);
        end
        rsp_we_i = 1'b0;
        rsp_size_i = 6'(rsp.size());
        dispatch_done_i = 1'b1;
        done_cyc = cyc;
        @(negedge clk_i);
        dispatch_done_i = 1'b0;
      end
    end
  end

  task automatic wait_ack(input logic v);
    for (int n = 0; n < 400 && ack_no !== v; n++) @(negedge clk_i);
    if (v == 1'b0) last_fall = cyc;
  endtask

  task automatic host_out(input logic [7:0] b, input int hold = 0);
    @(negedge clk_i);
    sr_dir_h2d_i = 1'b1; sr_data_i = b; req_ni = 1'b0;
    wait_ack(1'b0);
    repeat (hold) @(negedge clk_i);
    req_ni = 1'b1;
    wait_ack(1'b1);
    @(negedge clk_i);
  endtask

  task automatic host_in(output logic [7:0] b);
    @(negedge clk_i);
    sr_dir_h2d_i = 1'b0; req_ni = 1'b0;
    wait_ack(1'b0);
    @(negedge clk_i);
    b = sr_data_o;
    req_ni = 1'b1;
    wait_ack(1'b1);
    @(negedge clk_i);
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 200 && phase_o !== 2'd0; n++) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    tests++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] b;
    int i0, e0, d0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(ack_no === 1'b1, "R1 ack", ack_no, 1);
    chk(phase_o === 2'd0, "R1 phase", phase_o, 0);
    chk(sr_irq_o === 1'b0 && dispatch_valid_o === 1'b0, "R1 pulses", sr_irq_o, 0);
    chk(sr_data_o === 8'h00, "R1 sr", sr_data_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R3/R7/R9: op 0x01, fixed 4-byte response, slow executor
    exec_delay = 8;
    i0 = irq_cnt; d0 = dv_cnt;
    host_out(8'h01);
    chk(dv_cnt == d0 + 1 && dv_op == 8'h01 && dv_len == 8'd0, "R7 dispatch 01", dv_op, 8'h01);
    host_in(b);
    chk(last_fall > done_cyc, "R3 deferred ack", last_fall, done_cyc + 1);
    chk(b == 8'hA0, "R9 byte0", b, 8'hA0);
    for (int k = 1; k < 4; k++) begin
      host_in(b);
      chk(b == 8'(8'hA0 + k), "R9 byte", b, 8'hA0 + k);
    end
    chk(phase_o == 2'd0, "R9 back to idle", phase_o, 0);
    chk(irq_cnt == i0 + 5, "R12 irq count", irq_cnt - i0, 5);
    exec_delay = 2;

    // R4/R7/R10/R2: op 0x02, 4 args, empty fixed response, one held request
    d0 = dv_cnt; i0 = irq_cnt;
    host_out(8'h02);
    chk(phase_o == 2'd1, "R4 enter cmd", phase_o, 1);
    host_out(8'h11, 6);
    chk(irq_cnt == i0 + 2, "R2 single byte per request", irq_cnt - i0, 2);
    host_out(8'h22); host_out(8'h33);
    chk(dv_cnt == d0, "R7 no early dispatch", dv_cnt - d0, 0);
    host_out(8'h44);
    chk(dv_cnt == d0 + 1 && dv_len == 8'd4, "R7 dispatch len", dv_len, 4);
    wait_idle();
    chk(phase_o == 2'd0, "R10 zero fixed response", phase_o, 0);
    chk(seen_cmd.size() == 4 && seen_cmd[0] == 8'h11 && seen_cmd[3] == 8'h44,
        "R6 buffer contents", seen_cmd.size() == 4 ? seen_cmd[3] : 0, 8'h44);

    // R5/R8: variable command of 5, echoed as variable response
    host_out(8'h03); host_out(8'd5);
    for (int k = 0; k < 5; k++) host_out(8'(9 - k));
    chk(dv_len == 8'd5, "R5 length byte", dv_len, 5);
    host_in(b);
    chk(b == 8'd5, "R8 size byte", b, 5);
    for (int k = 0; k < 5; k++) begin
      host_in(b);
      chk(b == 8'(9 - k), "R8 echo byte", b, 9 - k);
    end
    chk(phase_o == 2'd0, "R8 idle after", phase_o, 0);

    // R6: 40 args, first 32 kept
    host_out(8'h03); host_out(8'd40);
    for (int k = 0; k < 40; k++) host_out(8'(k));
    chk(dv_len == 8'd40, "R6 count continues", dv_len, 40);
    host_in(b);
    chk(b == 8'd32, "R6 clamped size", b, 32);
    for (int k = 0; k < 32; k++) begin
      host_in(b);
      chk(b == 8'(k), "R6 kept byte", b, k);
    end
    chk(phase_o == 2'd0, "R6 idle after", phase_o, 0);

    // R10: variable command of zero length, empty variable response
    d0 = dv_cnt;
    host_out(8'h03); host_out(8'd0);
    chk(dv_cnt == d0 + 1, "R7 dispatch on zero length", dv_cnt - d0, 1);
    host_in(b);
    chk(b == 8'd0 && phase_o == 2'd0, "R10 empty variable response", b, 0);

    // R8: op 0x04 with n=3
    host_out(8'h04); host_out(8'd3);
    host_in(b);
    chk(b == 8'd3, "R8 size from executor", b, 3);
    for (int k = 0; k < 3; k++) begin
      host_in(b);
      chk(b == 8'(8'h50 + k), "R8 data", b, 8'h50 + k);
    end

    // R13: unhandled 0x05 fixed 3 zeros; R11 wrong direction in response phase
    d0 = dv_cnt; e0 = err_cnt; i0 = irq_cnt;
    host_out(8'h05);
    chk(phase_o == 2'd3, "R13 straight to response", phase_o, 3);
    host_out(8'h99);
    chk(err_cnt == e0 + 1 && irq_cnt == i0 + 1, "R11 err in rsp", err_cnt - e0, 1);
    chk(phase_o == 2'd3, "R11 phase kept", phase_o, 3);
    for (int k = 0; k < 3; k++) begin
      host_in(b);
      chk(b == 8'h00, "R13 zero byte", b, 0);
    end
    chk(phase_o == 2'd0 && dv_cnt == d0, "R13 no dispatch, idle", dv_cnt - d0, 0);

    // R13: unhandled 0x06 (2 args, variable) and default opcode
    d0 = dv_cnt;
    host_out(8'h06); host_out(8'h01); host_out(8'h02);
    host_in(b);
    chk(b == 8'h00 && phase_o == 2'd0, "R13 empty var response", b, 0);
    host_out(8'h77);
    host_in(b);
    chk(b == 8'h00 && phase_o == 2'd0, "R13 default opcode", b, 0);
    chk(dv_cnt == d0, "R13 no dispatch", dv_cnt - d0, 0);

    // R11: wrong direction in idle and in command receive
    e0 = err_cnt; i0 = irq_cnt;
    host_in(b);
    chk(err_cnt == e0 + 1 && irq_cnt == i0, "R11 err in idle", err_cnt - e0, 1);
    chk(phase_o == 2'd0 && b == 8'h00, "R11 idle unchanged", phase_o, 0);
    host_out(8'h02); host_out(8'hC1);
    host_in(b);
    chk(err_cnt == e0 + 2, "R11 err in cmd", err_cnt - e0, 2);
    host_out(8'hC2); host_out(8'hC3); host_out(8'hC4);
    wait_idle();
    chk(seen_cmd.size() == 4 && seen_cmd[1] == 8'hC2, "R11 count unchanged",
        seen_cmd.size(), 4);

    repeat (4) @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule